// File: doc/BRIEF.md
# MDIO Command Bridge

This block lets a host reach the registers of an internal PHY without driving the MDIO pins itself. The host sees two 16-bit registers. One is a command register, which holds the operation, the PHY address, the register number and a self-clearing busy bit. The other is a data register, which holds the payload for a write and the result of a read. Writing a valid command with the busy bit set starts one clause-22 management frame. The block generates MDC from the system clock and shifts the frame out on MDIO.

For a write, the host first loads the data register and then issues the command. For a read, the host issues the command, polls until busy clears and then reads the data register. While a frame is in flight, host writes to either register are dropped. A malformed command never reaches the wire.

Top module: `mdio_cmd_bridge`

## Requirements
- R1: After reset, the command register reads 0x0000, the data register reads 0x0000, and mdc and mdio_oe are both 0.
- R2: Outside a frame, a write to offset 1 (reg_sel=1) stores reg_wdata, and the data register reads back that value. A write frame leaves the data register unchanged.
- R3: A command written at offset 0 with bit 15 set, bit 12 set and bits 11:10 equal to 01 (write) or 10 (read) reads back with bit 15 = 1 from the next cycle until its frame ends. After that it reads back with bit 15 = 0, and bits 14:0 keep their written values.
- R4: A write frame drives its bits MSB first, each held for one MDC period and stable at the MDC rising edge. The bits are 32 ones, then 01, then 01, then PHY address cmd[9:5], then register cmd[4:0], then 10, then the 16 data-register bits. mdio_oe is 1 for all 64 bits.
- R5: A read frame sends the same header with opcode 10 and releases mdio_oe from bit 46 (the turnaround) to the end of the frame. It samples mdio_i on the MDC rising edges of bits 48 to 63, MSB first, into the data register.
- R6: While busy is 1, writes to the data register and to the command register have no effect on the frame or on either register.
- R7: A command with bit 15 set, but with bit 12 clear or with bits 11:10 equal to 00 or 11, reads back with bit 15 = 0 on the next cycle and produces no MDC edge.
- R8: MDC stays 0 while idle. During a frame, each half period of MDC lasts DIV system clock cycles, and mdio_o changes only after MDC falls.
- R9: A command written with bit 15 = 0 is stored as written and starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A scoreboard checks every frame bit by bit, including the output enable. This catches a design that sends the wrong opcode or swaps the address fields, and one that keeps driving through a read turnaround and so fights the PHY. Writes issued in the middle of a frame target both registers. A design that accepts them shows a changed payload, a corrupted data register or a command that reads back wrong. Malformed commands and commands with the start bit clear are checked for silence on MDC: a design that launched them anyway would emit clock edges and leave busy stuck high. The MDC half period is measured against the divider setting.

// File: rtl/mdio_cmd_bridge.sv
`timescale 1ns/1ps
module mdio_cmd_bridge #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [14:0] cmd_q;
  logic        busy;
  logic        rd_q;
  logic [15:0] data_q;
  logic [63:0] tx_q;
  logic [15:0] rx_q;
  logic [5:0]  bit_q;
  logic [CW-1:0] div_q;
  logic        mdc_q;

  logic cmd_wr, data_wr, start_ok, tick, rise, fall;

  assign cmd_wr   = reg_we && !reg_sel && !busy;
  assign data_wr  = reg_we && reg_sel && !busy;
  assign start_ok = reg_wdata[15] && reg_wdata[12] && (reg_wdata[11] ^ reg_wdata[10]);
  assign tick     = busy && (div_q == CW'(DIV - 1));
  assign rise     = tick && !mdc_q;
  assign fall     = tick && mdc_q;

  assign reg_rdata = reg_sel ? data_q : {busy, cmd_q};
  assign mdc       = mdc_q;
  assign mdio_oe   = busy && (!rd_q || bit_q < 6'd46);
  assign mdio_o    = !busy || tx_q[63];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy   <= 1'b0;
      rd_q   <= 1'b0;
      data_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      mdc_q  <= 1'b0;
    end else begin
      if (cmd_wr) begin
        cmd_q <= reg_wdata[14:0];
        if (start_ok) begin
          busy  <= 1'b1;
          rd_q  <= reg_wdata[11];
          tx_q  <= {32'hFFFF_FFFF, 2'b01, reg_wdata[11:10], reg_wdata[9:5],
                    reg_wdata[4:0], 2'b10, data_q};
          bit_q <= '0;
          div_q <= '0;
          mdc_q <= 1'b0;
        end
      end
      if (data_wr) data_q <= reg_wdata;
      if (busy) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) mdc_q <= ~mdc_q;
        if (rise && rd_q && bit_q >= 6'd48) rx_q <= {rx_q[14:0], mdio_i};
        if (fall) begin
          if (bit_q == 6'd63) begin
            busy <= 1'b0;
            if (rd_q) data_q <= rx_q;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[62:0], 1'b0};
          end
        end
      end
    end
  end

  AST_IDLE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mdc && !mdio_oe)); // R8
  AST_MDIO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mdc) |-> $stable(mdio_o)); // R8
  AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ($past(busy) && busy) |-> $stable(data_q)); // R6
  AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ($past(busy) && busy) |-> $stable(reg_rdata[14:0]) || reg_sel || $past(reg_sel)); // R6
  AST_BAD_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (reg_we && !reg_sel && !busy && !start_ok) |=> !busy); // R7
  AST_GOOD_CMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (cmd_wr && start_ok) |=> reg_rdata[15] || reg_sel); // R3
endmodule

// File: tb/mdio_cmd_bridge_bench.sv
`timescale 1ns/1ps
module mdio_cmd_bridge_bench;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0, reg_we = 0, reg_sel = 0, mdio_i = 1;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;

  mdio_cmd_bridge #(.DIV(DIV)) u_mdio_cmd_bridge (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  always #10 clk = ~clk;

  int total = 0, fails = 0, frames = 0, mdc_edges = 0, n = 0;
  bit finished = 0;
  logic [64:0] exp_q[$];
  logic [63:0] cap, oe_cap;
  logic [15:0] cur_val = 0;

  function automatic logic [15:0] phy_val(logic [4:0] p, logic [4:0] r);
    return {~r, p, 1'b1, r};
  endfunction

  function automatic logic [63:0] mk_frame(logic [15:0] c, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, c[11:10], c[9:5], c[4:0], 2'b10, d};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge mdc) begin
    #1;
    mdc_edges++;
    cap = {cap[62:0], mdio_o};
    oe_cap = {oe_cap[62:0], mdio_oe};
    n++;
    if (n == 48) cur_val = phy_val(cap[11:7], cap[6:2]);
    if (n == 64) begin
      logic [64:0] e;
      n = 0;
      frames++;
      if (exp_q.size() == 0) chk(0, "R4 unexpected frame", cap, 0);
      else begin
        e = exp_q.pop_front();
        if (e[64]) begin
          chk(cap[63:18] == e[63:18], "R5 read header", cap, e[63:0]);
          chk(oe_cap == {{46{1'b1}}, 18'b0}, "R5 read oe", oe_cap, {{46{1'b1}}, 18'b0});
        end else begin
          chk(cap == e[63:0], "R4 write frame", cap, e[63:0]);
          chk(oe_cap == '1, "R4 write oe", oe_cap, '1);
        end
      end
    end
  end

  always @(negedge mdc) begin
    #1;
    if (n >= 48 && n < 64) mdio_i = cur_val[63-n];
    else mdio_i = 1'b1;
  end

  task automatic hw(bit sel, logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic hr(bit sel, output logic [15:0] d);
    @(negedge clk); reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 2000; i++) begin
      hr(0, v);
      if (!v[15]) return;
    end
    chk(0, "R3 busy stuck", 1, 0);
  endtask

  task automatic issue(logic [15:0] c, logic [15:0] d);
    exp_q.push_back({c[11], mk_frame(c, d)});
    hw(0, c);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int e0, f0;
    realtime t0, t1;
    repeat (3) @(negedge clk);
    hr(0, v); chk(v == 0, "R1 cmd reset", v, 0);
    hr(1, v); chk(v == 0, "R1 data reset", v, 0);
    chk(mdc == 0 && mdio_oe == 0, "R1 pins reset", {mdc, mdio_oe}, 0);
    rst_n = 1;
    @(negedge clk);

    hw(1, 16'hA5C3);
    hr(1, v); chk(v == 16'hA5C3, "R2 data readback", v, 16'hA5C3);

    issue(16'h9469, 16'hA5C3);
    hr(0, v); chk(v == 16'h9469, "R3 busy set", v, 16'h9469);
    @(posedge mdc); t0 = $realtime;
    @(negedge mdc); t1 = $realtime;
    chk((t1 - t0) == DIV * 20.0, "R8 mdc half period", 64'(int'(t1 - t0)), DIV * 20);
    wait_idle();
    hr(0, v); chk(v == 16'h1469, "R3 busy cleared", v, 16'h1469);
    hr(1, v); chk(v == 16'hA5C3, "R2 data kept after write", v, 16'hA5C3);

    hw(1, 16'h0001);
    issue(16'h97E0, 16'h0001);
    wait_idle();

    issue(16'h98B1, 16'h0);
    wait_idle();
    hr(1, v); chk(v == phy_val(5, 17), "R5 read result", v, phy_val(5, 17));
    issue(16'h981F, 16'h0);
    wait_idle();
    hr(1, v); chk(v == phy_val(0, 31), "R5 read result 2", v, phy_val(0, 31));

    hw(1, 16'h5A5A);
    issue(16'h9444, 16'h5A5A);
    repeat (20) @(negedge clk);
    hw(1, 16'h1234);
    hw(0, 16'h98FF);
    wait_idle();
    hr(1, v); chk(v == 16'h5A5A, "R6 data ignored", v, 16'h5A5A);
    hr(0, v); chk(v == 16'h1444, "R6 cmd ignored", v, 16'h1444);

    e0 = mdc_edges; f0 = frames;
    hw(0, 16'h8469); hr(0, v); chk(v[15] == 0, "R7 bit12 clear", v, 16'h0469);
    hw(0, 16'h9069); hr(0, v); chk(v[15] == 0, "R7 op 00", v, 16'h1069);
    hw(0, 16'h9C69); hr(0, v); chk(v[15] == 0, "R7 op 11", v, 16'h1C69);
    repeat (700) @(negedge clk);
    chk(mdc_edges == e0 && frames == f0, "R7 no frame", 64'(mdc_edges), 64'(e0));

    hw(0, 16'h1469); hr(0, v); chk(v == 16'h1469, "R9 stored", v, 16'h1469);
    repeat (700) @(negedge clk);
    chk(mdc_edges == e0, "R9 no frame", 64'(mdc_edges), 64'(e0));

    chk(exp_q.size() == 0 && frames == 5, "R4 frame count", 64'(frames), 5);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule